// File: doc/BRIEF.md
# Integer ALU with Flag Register and Branch Decision

This block performs the arithmetic and logic step of a small integer datapath. Two operands arrive together with a two-bit operation select. The block returns, in the same cycle, their sum, their difference, their bitwise AND or their bitwise XOR. Alongside the result it computes three status flags for that result: a zero flag, a sign flag and a signed-overflow flag.

The flags are held in a small register. That register loads only in cycles where the surrounding control marks the current instruction as an arithmetic/logic one. Data moves, jumps and stack traffic leave the flags untouched.

A branch evaluator reads the stored flags, never the in-flight ones. From a four-bit jump condition code it decides whether a jump is taken.

Top module: `alu_branch_unit`

## Requirements
- R1: With `alu_fn` = 0 the result is `op_b + op_a`, truncated to WIDTH bits.
- R2: With `alu_fn` = 1 the result is `op_b - op_a`, truncated to WIDTH bits. The second operand is the minuend.
- R3: With `alu_fn` = 2 the result is `op_b & op_a`. With `alu_fn` = 3 it is `op_b ^ op_a`.
- R4: On a rising clock edge with `set_cc` high and `rst` low, `cc_zf` takes 1 exactly when the result is all zeros, and `cc_sf` takes the result's most significant bit.
- R5: The overflow flag captured with `set_cc` follows these rules:
  - For an add it is 1 when both operands have the same sign and the result's sign differs.
  - For a subtract it is 1 when the operand signs differ and the result's sign differs from `op_b`.
  - For AND and XOR it is 0.
- R6: On a rising edge with `set_cc` low and `rst` low, all three flags keep their values, whatever the operands and `alu_fn`.
- R7: On a rising edge with `rst` high (synchronous reset), the flags become ZF=1, SF=0, OF=0.
- R8: `take_branch` decodes `jmp_fn` as follows, with less = SF xor OF:
  - 0: always taken.
  - 1: less or ZF.
  - 2: less.
  - 3: ZF.
  - 4: not ZF.
  - 5: not less.
  - 6: neither less nor ZF.
- R9: For `jmp_fn` values 7 to 15, `take_branch` is 0.
- R10: `take_branch` depends only on the stored flags and `jmp_fn`. Changing the operands or `alu_fn` between clock edges does not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flag register loads on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| op_a | input | WIDTH | First operand (subtrahend for subtract) |
| op_b | input | WIDTH | Second operand |
| alu_fn | input | 2 | Operation select: 0 add, 1 subtract, 2 AND, 3 XOR |
| set_cc | input | 1 | Load the flags from this cycle's result |
| jmp_fn | input | 4 | Jump condition code |
| result | output | WIDTH | Combinational operation result |
| cc_zf | output | 1 | Stored zero flag |
| cc_sf | output | 1 | Stored sign flag |
| cc_of | output | 1 | Stored overflow flag |
| take_branch | output | 1 | Jump decision from the stored flags |

## Verification
Several properties are checked on every cycle:
- the flags hold when no load is requested;
- zero and sign are captured from the previous cycle's result;
- logic operations clear overflow;
- reset restores the flag pattern;
- the equality condition and the undefined codes map onto the stored flags as required.

Only the bench's scenarios can show the rest. These are the arithmetic of add and subtract over a swept operand space, and the signed-overflow boundaries at the most negative value. They also include every jump condition over every reachable flag combination. Finally, the bench shows that the branch decision stays unchanged while the operands already produce a different flag pattern.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

  localparam int ALU_FN_W = 2;
  localparam int JMP_FN_W = 4;

  typedef enum logic [ALU_FN_W-1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_XOR = 2'd3
  } alu_fn_e;

  typedef enum logic [JMP_FN_W-1:0] {
    JC_ALWAYS = 4'd0,
    JC_LE     = 4'd1,
    JC_LT     = 4'd2,
    JC_EQ     = 4'd3,
    JC_NE     = 4'd4,
    JC_GE     = 4'd5,
    JC_GT     = 4'd6
  } jmp_cond_e;

  typedef struct packed {
    logic of;
    logic zf;
    logic sf;
  } cc_t;

  localparam cc_t CC_RESET = '{of: 1'b0, zf: 1'b1, sf: 1'b0};

endpackage

// File: rtl/alu_core.sv
module alu_core
  import alu_cc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]    op_a,
  input  logic [WIDTH-1:0]    op_b,
  input  logic [ALU_FN_W-1:0] fn,
  output logic [WIDTH-1:0]    result,
  output cc_t                 next_cc
);

  localparam int MSB = WIDTH - 1;

  alu_fn_e          fn_e;
  logic             is_sub;
  logic [WIDTH-1:0] addend;
  logic [WIDTH-1:0] sum;
  logic             arith_ovf;

  assign fn_e   = alu_fn_e'(fn);
  assign is_sub = (fn_e == ALU_SUB);

  // One adder serves both add and subtract: b - a = b + ~a + 1.
  assign addend = is_sub ? ~op_a : op_a;
  assign sum    = op_b + addend + WIDTH'(is_sub);

  // Signed overflow: equal-signed inputs to the adder, result sign differs.
  assign arith_ovf = (op_b[MSB] == addend[MSB]) && (sum[MSB] != op_b[MSB]);

  always_comb begin
    unique case (fn_e)
      ALU_ADD, ALU_SUB: result = sum;
      ALU_AND:          result = op_b & op_a;
      ALU_XOR:          result = op_b ^ op_a;
      default:          result = '0;
    endcase
  end

  always_comb begin
    next_cc.zf = ~|result;
    next_cc.sf = result[MSB];
    next_cc.of = (fn_e == ALU_ADD || fn_e == ALU_SUB) ? arith_ovf : 1'b0;
  end

endmodule

// File: rtl/cc_reg.sv
module cc_reg
  import alu_cc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  cc_t  d,
  output cc_t  q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= CC_RESET;
    end else if (load) begin
      q <= d;
    end
  end

endmodule

// File: rtl/branch_eval.sv
module branch_eval
  import alu_cc_pkg::*;
(
  input  cc_t                 cc,
  input  logic [JMP_FN_W-1:0] jmp_fn,
  output logic                take
);

  logic lt;
  logic le;

  assign lt = cc.sf ^ cc.of;
  assign le = lt | cc.zf;

  always_comb begin
    case (jmp_cond_e'(jmp_fn))
      JC_ALWAYS: take = 1'b1;
      JC_LE:     take = le;
      JC_LT:     take = lt;
      JC_EQ:     take = cc.zf;
      JC_NE:     take = ~cc.zf;
      JC_GE:     take = ~lt;
      JC_GT:     take = ~le;
      default:   take = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_branch_unit.sv
module alu_branch_unit
  import alu_cc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [1:0]       alu_fn,
  input  logic             set_cc,
  input  logic [3:0]       jmp_fn,
  output logic [WIDTH-1:0] result,
  output logic             cc_zf,
  output logic             cc_sf,
  output logic             cc_of,
  output logic             take_branch
);

  cc_t next_cc;
  cc_t stored_cc;

  alu_core #(.WIDTH(WIDTH)) u_core (
    .op_a    (op_a),
    .op_b    (op_b),
    .fn      (alu_fn),
    .result  (result),
    .next_cc (next_cc)
  );

  cc_reg u_cc (
    .clk  (clk),
    .rst  (rst),
    .load (set_cc),
    .d    (next_cc),
    .q    (stored_cc)
  );

  branch_eval u_br (
    .cc     (stored_cc),
    .jmp_fn (jmp_fn),
    .take   (take_branch)
  );

  assign cc_zf = stored_cc.zf;
  assign cc_sf = stored_cc.sf;
  assign cc_of = stored_cc.of;

endmodule

// File: rtl/alu_branch_unit_chk.sv
module alu_branch_unit_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [1:0]       alu_fn,
  input logic             set_cc,
  input logic [3:0]       jmp_fn,
  input logic [WIDTH-1:0] result,
  input logic             cc_zf,
  input logic             cc_sf,
  input logic             cc_of,
  input logic             take_branch
);

  assert_add_result_R1: assert property (@(posedge clk) disable iff (rst)
    (alu_fn == 2'd0) |-> (result == WIDTH'(op_a + op_b)));

  assert_zero_capture_R4: assert property (@(posedge clk) disable iff (rst)
    set_cc |=> (cc_zf == ($past(result) == '0)));

  assert_sign_capture_R4: assert property (@(posedge clk) disable iff (rst)
    set_cc |=> (cc_sf == $past(result[WIDTH-1])));

  assert_logic_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (set_cc && alu_fn[1]) |=> !cc_of);

  assert_flags_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !set_cc |=> $stable({cc_of, cc_zf, cc_sf}));

  assert_reset_flags_R7: assert property (@(posedge clk)
    rst |=> (cc_zf && !cc_sf && !cc_of));

  assert_equal_cond_R8: assert property (@(posedge clk) disable iff (rst)
    (jmp_fn == 4'd3) |-> (take_branch == cc_zf));

  assert_undefined_jump_R9: assert property (@(posedge clk) disable iff (rst)
    (jmp_fn > 4'd6) |-> !take_branch);

endmodule

bind alu_branch_unit alu_branch_unit_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/alu_branch_unit_bench.sv
module alu_branch_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int MASK       = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] op_a, op_b;
  logic [1:0]   alu_fn;
  logic         set_cc;
  logic [3:0]   jmp_fn;
  logic [W-1:0] result;
  logic         cc_zf, cc_sf, cc_of, take_branch;

  int n_checks = 0;
  int n_fail   = 0;

  // bench flag model
  bit m_zf, m_sf, m_of;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_branch_unit #(.WIDTH(W)) u_alu_branch_unit (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .alu_fn(alu_fn),
    .set_cc(set_cc), .jmp_fn(jmp_fn), .result(result),
    .cc_zf(cc_zf), .cc_sf(cc_sf), .cc_of(cc_of), .take_branch(take_branch)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h (a=0x%0h b=0x%0h fn=%0d jf=%0d)",
               req, got, exp, op_a, op_b, alu_fn, jmp_fn);
    end
  endtask

  function automatic int sx(input int v);
    return (v >= (1 << (W-1))) ? v - (1 << W) : v;
  endfunction

  function automatic int exp_result(input int a, input int b, input int fn);
    case (fn)
      0: return (b + a) & MASK;
      1: return (b - a) & MASK;
      2: return b & a;
      default: return b ^ a;
    endcase
  endfunction

  function automatic bit exp_ovf(input int a, input int b, input int fn);
    int s;
    if (fn == 0) s = sx(b) + sx(a);
    else if (fn == 1) s = sx(b) - sx(a);
    else return 1'b0;
    return (s > (1 << (W-1)) - 1) || (s < -(1 << (W-1)));
  endfunction

  function automatic bit exp_take(input int jf, input bit z, input bit s, input bit o);
    bit lt;
    lt = s ^ o;
    case (jf)
      0: return 1'b1;
      1: return lt | z;
      2: return lt;
      3: return z;
      4: return !z;
      5: return !lt;
      6: return !(lt | z);
      default: return 1'b0;
    endcase
  endfunction

  task automatic check_take(input int jf);
    if (jf > 6) chk("R9 undefined jump", int'(take_branch), 0);
    else        chk("R8 jump condition", int'(take_branch), int'(exp_take(jf, m_zf, m_sf, m_of)));
  endtask

  // Flag-loading operation: drive at negedge, check after the capturing edge.
  task automatic do_cc(input int a, input int b, input int fn, input int jf);
    int r;
    @(negedge clk);
    op_a = W'(a); op_b = W'(b); alu_fn = 2'(fn); jmp_fn = 4'(jf); set_cc = 1'b1;
    r = exp_result(a, b, fn);
    @(posedge clk);
    #1;
    m_zf = (r == 0);
    m_sf = r[W-1];
    m_of = exp_ovf(a, b, fn);
    chk("R4 zero flag", int'(cc_zf), int'(m_zf));
    chk("R4 sign flag", int'(cc_sf), int'(m_sf));
    chk("R5 overflow flag", int'(cc_of), int'(m_of));
    check_take(jf);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int iter;
    rst = 1'b1; set_cc = 1'b0; op_a = '0; op_b = '0; alu_fn = '0; jmp_fn = '0;
    repeat (2) @(posedge clk);
    #1;
    chk("R7 reset zf", int'(cc_zf), 1);
    chk("R7 reset sf", int'(cc_sf), 0);
    chk("R7 reset of", int'(cc_of), 0);
    m_zf = 1; m_sf = 0; m_of = 0;
    for (int jf = 0; jf < 16; jf++) begin
      jmp_fn = 4'(jf); #1;
      check_take(jf);
    end
    @(negedge clk);
    rst = 1'b0;

    // Combinational sweep of all four operations (R1, R2, R3)
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b += 17) begin
        for (int fn = 0; fn < 4; fn++) begin
          op_a = W'(a); op_b = W'(b); alu_fn = 2'(fn);
          #1;
          case (fn)
            0: chk("R1 add", int'(result), exp_result(a, b, fn));
            1: chk("R2 sub", int'(result), exp_result(a, b, fn));
            default: chk("R3 logic", int'(result), exp_result(a, b, fn));
          endcase
        end
      end
    end

    // Overflow and sign corner cases
    do_cc(8'h80, 8'h80, 0, 3);  // -128 + -128 = 0, OF, ZF
    do_cc(8'h01, 8'h7f, 0, 2);  // 127 + 1 overflows
    do_cc(8'h80, 8'h00, 1, 5);  // 0 - (-128) overflows
    do_cc(8'h01, 8'h80, 1, 6);  // -128 - 1 overflows
    do_cc(8'h80, 8'hff, 1, 1);  // -1 - (-128) = 127, no OF
    do_cc(8'h05, 8'h05, 1, 4);  // equal operands -> zero
    do_cc(8'hff, 8'hff, 3, 3);  // xor to zero, OF cleared
    do_cc(8'hf0, 8'h8f, 2, 2);  // and negative

    // Swept flag capture with rotating jump codes (R4, R5, R8, R9)
    iter = 0;
    for (int a = 0; a < 256; a += 5) begin
      for (int b = 0; b < 256; b += 7) begin
        for (int fn = 0; fn < 4; fn++) begin
          do_cc(a, b, fn, iter % 16);
          iter++;
        end
      end
    end

    // R6 / R10: flags hold and branch ignores in-flight result
    do_cc(8'h01, 8'h00, 1, 3);  // 0 - 1 = 0xff: ZF=0, SF=1
    @(negedge clk);
    set_cc = 1'b0; op_a = 8'h00; op_b = 8'h00; alu_fn = 2'd0; jmp_fn = 4'd3;
    #1;
    chk("R10 branch uses stored flags", int'(take_branch), 0);
    @(posedge clk);
    #1;
    chk("R6 zf held", int'(cc_zf), 0);
    chk("R6 sf held", int'(cc_sf), 1);
    chk("R6 of held", int'(cc_of), 0);
    chk("R10 branch after non-loading edge", int'(take_branch), 0);
    @(negedge clk);
    op_a = 8'h7f; op_b = 8'h7f; alu_fn = 2'd0; jmp_fn = 4'd2;  // would set OF
    @(posedge clk);
    #1;
    chk("R6 of held after overflowing add", int'(cc_of), 0);
    chk("R6 sf held after overflowing add", int'(cc_sf), 1);
    chk("R8 less from held flags", int'(take_branch), 1);

    // Reset in mid-run (R7)
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R7 mid-run reset zf", int'(cc_zf), 1);
    chk("R7 mid-run reset sf", int'(cc_sf), 0);
    chk("R7 mid-run reset of", int'(cc_of), 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    finish_run();
  end

endmodule